// File: doc/BRIEF.md
# NAND Flash Image Loader with Bad-Block Skipping

This block copies a contiguous image out of NAND flash into a memory write port. Software-free boot logic hands it a flash byte offset, an image length and a destination address, then pulses `start`. The loader works through the erase blocks that the image spans. For each block it first asks a command sequencer for the bad-block marker word in the spare area of page 0. A block whose marker is not all ones is skipped. A good block has its pages requested in ascending order, and every returned data word is written to memory at a destination address that grows without gaps.

A skipped block does not use up image length. Each skip moves the limit block one place further, so the image still receives as many good blocks as the offset range spans. The starting page, taken from the offset, applies to the first block that turns out to be good. Every block after that one starts at page 0. The block does not correct errors and does not generate flash bus timing. The sequencer below it handles both.

Top module: `nand_image_loader`

## Requirements
- R1: A start with an offset that is not a multiple of the page size, or with a zero length, is refused. `reqErr` is high for exactly the one cycle after the start edge, `busy` stays low and no command is requested.
- R2: The first command after an accepted start is a marker read (`cmdSpare`=1) of block offset/block_bytes, page 0, at column PAGE_WORDS + MARKER_BYTE/(BUS_W/8). Columns are counted in bus words from the start of the page.
- R3: A marker word equal to all ones (0xFF on an 8-bit bus, 0xFFFF on a 16-bit bus) marks a good block, and any other value marks a bad one. For a bad block, no page read is issued, `badCount` increments and the next command is the marker read of the following block.
- R4: The first good block is read from page (offset mod block_bytes)/page_bytes. Every later good block is read from page 0. Pages go in ascending order up to PAGES_PER_BLOCK-1, each read with `cmdSpare`=0 and column 0.
- R5: Each data word returned during a page read appears in the same cycle on `memWe`/`memData`. The addresses are dst, dst+BUS_W/8, and so on, and they run on without gaps across pages and blocks.
- R6: The number of good blocks loaded equals last-first+1. Here first = offset/block_bytes and last = (offset+length-1)/block_bytes, whatever the number of bad blocks.
- R7: `busy` is high from the cycle after an accepted start until the final word is written. `done` is high for exactly one cycle, the cycle after that final write, and `busy` is low in that cycle.
- R8: `badCount` is zero after reset and is cleared by an accepted start. It holds its value after `done` until the next accepted start.
- R9: While `cmdReq` is high and `cmdGnt` is low, the request and all its fields stay unchanged in the next cycle.
- R10: `start` has no effect while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a load, sampled while idle |
| flashOffs | input | OFFS_W | Image byte offset in flash |
| imageLen | input | LEN_W | Image length in bytes |
| dstAddr | input | ADDR_W | First destination byte address |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle completion pulse |
| reqErr | output | 1 | One-cycle pulse: request refused |
| badCount | output | CNT_W | Bad blocks skipped in this load |
| cmdReq | output | 1 | Read command request to sequencer |
| cmdGnt | input | 1 | Sequencer accepts the request |
| cmdSpare | output | 1 | 1: single-word marker read, 0: full page read |
| cmdBlock | output | BLK_W | Erase block index |
| cmdPage | output | PPB_LG | Page within block |
| cmdCol | output | COL_W | Start column in bus words |
| rdValid | input | 1 | Returned data word valid |
| rdData | input | BUS_W | Returned data word |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | ADDR_W | Memory write byte address |
| memData | output | BUS_W | Memory write data |

## Verification
The bench targets a first block that is bad while the offset points into the middle of it. A loader that resets the page on a skip would read that next block from page 0 instead of the offset's page. Two bad blocks in a row check that the limit moves once per skip; a loader that counted original blocks would stop after block 0. A marker of 0xFE checks that a single cleared bit is enough to reject a block, and slow grants with gaps in the returned data show whether the request fields drift or the write addresses skip. Refused starts (unaligned offset, zero length) and a start pulse in the middle of a load check that neither reaches the sequencer.

// File: rtl/nand_ldr_pkg.sv
package nand_ldr_pkg;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;       // capture a new request
    logic skipBad;    // current block is bad: move on, extend limit
    logic takeWord;   // a page data word is being written out
    logic nextPage;   // advance page inside the block
    logic nextBlock;  // advance to next block, page 0
  } ldrStrobe_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_MREQ,
    S_MWAIT,
    S_PREQ,
    S_PDATA,
    S_DONE
  } ldrState_t;

endpackage

// File: rtl/nand_ldr_ctrl.sv
module nand_ldr_ctrl
  import nand_ldr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       reqOk,
  input  logic       cmdGnt,
  input  logic       rdValid,
  input  logic       markerGood,
  input  logic       wordLast,
  input  logic       pageLast,
  input  logic       blockLast,
  output ldrStrobe_t strb,
  output logic       cmdReq,
  output logic       cmdSpare,
  output logic       busy,
  output logic       done,
  output logic       reqErr
);

  ldrState_t state, nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      S_IDLE: begin
        if (start && reqOk) begin
          strb.load = 1'b1;
          nextState = S_MREQ;
        end
      end
      S_MREQ: if (cmdGnt) nextState = S_MWAIT;
      S_MWAIT: begin
        if (rdValid) begin
          if (markerGood) begin
            nextState = S_PREQ;
          end else begin
            strb.skipBad = 1'b1;
            nextState    = S_MREQ;
          end
        end
      end
      S_PREQ: if (cmdGnt) nextState = S_PDATA;
      S_PDATA: begin
        if (rdValid) begin
          strb.takeWord = 1'b1;
          if (wordLast) begin
            if (!pageLast) begin
              strb.nextPage = 1'b1;
              nextState     = S_PREQ;
            end else if (blockLast) begin
              nextState = S_DONE;
            end else begin
              strb.nextBlock = 1'b1;
              nextState      = S_MREQ;
            end
          end
        end
      end
      S_DONE:  nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      reqErr <= 1'b0;
    end else begin
      state  <= nextState;
      reqErr <= (state == S_IDLE) && start && !reqOk;
    end
  end

  assign cmdReq   = (state == S_MREQ) || (state == S_PREQ);
  assign cmdSpare = (state == S_MREQ);
  assign busy     = (state != S_IDLE) && (state != S_DONE);
  assign done     = (state == S_DONE);

  // R7: completion is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R1: a refused request never starts a load
  p_err_idle_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqErr |-> !busy && !cmdReq);

  // R9: an ungranted request is held with the same kind
  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && !cmdGnt |=> cmdReq && $stable(cmdSpare));

  // R10: a start pulse during a load does not reload
  p_start_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !strb.load);

endmodule

// File: rtl/nand_ldr_path.sv
module nand_ldr_path
  import nand_ldr_pkg::*;
#(
  parameter int BUS_W      = 8,
  parameter int OFFS_W     = 16,
  parameter int LEN_W      = 16,
  parameter int ADDR_W     = 16,
  parameter int CNT_W      = 8,
  parameter int PG_LG      = 4,
  parameter int PPB_LG     = 2,
  parameter int PAGE_WORDS = 16,
  parameter int BLK_W      = 12,
  parameter int SUM_W      = 17
) (
  input  logic              clk,
  input  logic              rstN,
  input  ldrStrobe_t        strb,
  input  logic [OFFS_W-1:0] flashOffs,
  input  logic [LEN_W-1:0]  imageLen,
  input  logic [ADDR_W-1:0] dstAddr,
  input  logic [BUS_W-1:0]  rdData,
  output logic              reqOk,
  output logic              markerGood,
  output logic              wordLast,
  output logic              pageLast,
  output logic              blockLast,
  output logic [BLK_W-1:0]  curBlock,
  output logic [PPB_LG-1:0] curPage,
  output logic [ADDR_W-1:0] dst,
  output logic [CNT_W-1:0]  badCount
);

  localparam int BLK_LG    = PG_LG + PPB_LG;
  localparam int WC_W      = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
  localparam int BUS_BYTES = BUS_W / 8;

  logic [SUM_W-1:0] endAddr;
  logic [BLK_W-1:0] lastBlock;
  logic [BLK_W-1:0] firstBlock;
  logic [BLK_W-1:0] limitInit;
  logic [WC_W-1:0]  wordCnt;

  assign endAddr    = SUM_W'(flashOffs) + SUM_W'(imageLen) - SUM_W'(1);
  assign firstBlock = BLK_W'(flashOffs >> BLK_LG);
  assign limitInit  = BLK_W'(endAddr >> BLK_LG);

  assign reqOk      = (flashOffs[PG_LG-1:0] == '0) && (imageLen != '0);
  assign markerGood = &rdData;
  assign wordLast   = (wordCnt == WC_W'(PAGE_WORDS - 1));
  assign pageLast   = (curPage == '1);
  assign blockLast  = (curBlock == lastBlock);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curBlock  <= '0;
      lastBlock <= '0;
      curPage   <= '0;
      wordCnt   <= '0;
      dst       <= '0;
      badCount  <= '0;
    end else if (strb.load) begin
      curBlock  <= firstBlock;
      lastBlock <= limitInit;
      curPage   <= flashOffs[BLK_LG-1:PG_LG];
      wordCnt   <= '0;
      dst       <= dstAddr;
      badCount  <= '0;
    end else begin
      if (strb.skipBad) begin
        // start page is kept for the first good block
        curBlock  <= curBlock + 1'b1;
        lastBlock <= lastBlock + 1'b1;
        badCount  <= badCount + 1'b1;
      end
      if (strb.takeWord) begin
        dst     <= dst + ADDR_W'(BUS_BYTES);
        wordCnt <= wordLast ? '0 : wordCnt + 1'b1;
      end
      if (strb.nextPage) curPage <= curPage + 1'b1;
      if (strb.nextBlock) begin
        curBlock <= curBlock + 1'b1;
        curPage  <= '0;
      end
    end
  end

  // R6: the current block never passes the limit block
  p_block_limit_r6: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> curBlock <= lastBlock);

  // R3: each skip adds one to the bad count
  p_skip_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.skipBad |=> badCount == $past(badCount) + 1'b1);

endmodule

// File: rtl/nand_image_loader.sv
module nand_image_loader
  import nand_ldr_pkg::*;
#(
  parameter int BUS_W           = 8,
  parameter int PAGE_BYTES      = 16,
  parameter int PAGES_PER_BLOCK = 4,
  parameter int MARKER_BYTE     = 0,
  parameter int OFFS_W          = 16,
  parameter int LEN_W           = 16,
  parameter int ADDR_W          = 16,
  parameter int CNT_W           = 8,
  localparam int BUS_BYTES  = BUS_W / 8,
  localparam int PAGE_WORDS = PAGE_BYTES / BUS_BYTES,
  localparam int PG_LG      = $clog2(PAGE_BYTES),
  localparam int PPB_LG     = $clog2(PAGES_PER_BLOCK),
  localparam int BLK_LG     = PG_LG + PPB_LG,
  localparam int SUM_W      = ((OFFS_W > LEN_W) ? OFFS_W : LEN_W) + 1,
  localparam int BLK_W      = SUM_W - BLK_LG + 1,
  localparam int COL_W      = $clog2(PAGE_WORDS) + 1,
  localparam int MARK_COL   = PAGE_WORDS + MARKER_BYTE / BUS_BYTES
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [OFFS_W-1:0] flashOffs,
  input  logic [LEN_W-1:0]  imageLen,
  input  logic [ADDR_W-1:0] dstAddr,
  output logic              busy,
  output logic              done,
  output logic              reqErr,
  output logic [CNT_W-1:0]  badCount,
  output logic              cmdReq,
  input  logic              cmdGnt,
  output logic              cmdSpare,
  output logic [BLK_W-1:0]  cmdBlock,
  output logic [PPB_LG-1:0] cmdPage,
  output logic [COL_W-1:0]  cmdCol,
  input  logic              rdValid,
  input  logic [BUS_W-1:0]  rdData,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BUS_W-1:0]  memData
);

  ldrStrobe_t strb;
  logic reqOk, markerGood, wordLast, pageLast, blockLast;
  logic [PPB_LG-1:0] pageIdx;

  nand_ldr_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .reqOk      (reqOk),
    .cmdGnt     (cmdGnt),
    .rdValid    (rdValid),
    .markerGood (markerGood),
    .wordLast   (wordLast),
    .pageLast   (pageLast),
    .blockLast  (blockLast),
    .strb       (strb),
    .cmdReq     (cmdReq),
    .cmdSpare   (cmdSpare),
    .busy       (busy),
    .done       (done),
    .reqErr     (reqErr)
  );

  nand_ldr_path #(
    .BUS_W      (BUS_W),
    .OFFS_W     (OFFS_W),
    .LEN_W      (LEN_W),
    .ADDR_W     (ADDR_W),
    .CNT_W      (CNT_W),
    .PG_LG      (PG_LG),
    .PPB_LG     (PPB_LG),
    .PAGE_WORDS (PAGE_WORDS),
    .BLK_W      (BLK_W),
    .SUM_W      (SUM_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .flashOffs  (flashOffs),
    .imageLen   (imageLen),
    .dstAddr    (dstAddr),
    .rdData     (rdData),
    .reqOk      (reqOk),
    .markerGood (markerGood),
    .wordLast   (wordLast),
    .pageLast   (pageLast),
    .blockLast  (blockLast),
    .curBlock   (cmdBlock),
    .curPage    (pageIdx),
    .dst        (memAddr),
    .badCount   (badCount)
  );

  // marker reads always target page 0 in the spare area
  assign cmdPage = cmdSpare ? '0 : pageIdx;
  assign cmdCol  = cmdSpare ? COL_W'(MARK_COL) : '0;
  assign memWe   = strb.takeWord;
  assign memData = rdData;

  // R9: request fields hold while waiting for the grant
  p_req_fields_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmdReq && !cmdGnt |=> $stable(cmdBlock) && $stable(cmdPage) && $stable(cmdCol));

  // R5: writes only happen inside a load
  p_write_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy && !cmdReq);

endmodule

// File: tb/nand_image_loader_tb.sv
`timescale 1ns/100ps
module nand_image_loader_tb;

  localparam int PB   = 16;
  localparam int PPB  = 4;
  localparam int BB   = PB * PPB;
  localparam int MCOL = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] flashOffs = '0;
  logic [15:0] imageLen = '0;
  logic [15:0] dstAddr = '0;
  logic        busy, done, reqErr;
  logic [7:0]  badCount;
  logic        cmdReq, cmdSpare;
  logic        cmdGnt = 1'b0;
  logic [11:0] cmdBlock;
  logic [1:0]  cmdPage;
  logic [4:0]  cmdCol;
  logic        rdValid = 1'b0;
  logic [7:0]  rdData = '0;
  logic        memWe;
  logic [15:0] memAddr;
  logic [7:0]  memData;

  always #2.5 clk = ~clk;

  nand_image_loader u_dut (
    .clk(clk), .rstN(rstN), .start(start), .flashOffs(flashOffs),
    .imageLen(imageLen), .dstAddr(dstAddr), .busy(busy), .done(done),
    .reqErr(reqErr), .badCount(badCount), .cmdReq(cmdReq), .cmdGnt(cmdGnt),
    .cmdSpare(cmdSpare), .cmdBlock(cmdBlock), .cmdPage(cmdPage), .cmdCol(cmdCol),
    .rdValid(rdValid), .rdData(rdData), .memWe(memWe), .memAddr(memAddr),
    .memData(memData)
  );

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;
  logic [63:0] badMask = '0;
  int gntDelay = 0;
  bit gapMode = 0;

  function automatic logic [7:0] dataOf(int b, int p, int w);
    return 8'((b * 29 + p * 7 + w * 3 + 1) & 255);
  endfunction

  function automatic logic [7:0] markerOf(int b);
    if (!badMask[b]) return 8'hFF;
    return (b % 2 == 1) ? 8'hFE : 8'h00;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // flash command sequencer model: drives just after the rising edge
  bit streaming = 0, startStream = 0, gapPh = 0, capSpare = 0;
  int waitCnt = 0, wIdx = 0, capBlk = 0, capPg = 0;
  always begin
    @(posedge clk);
    #1;
    cmdGnt  = 1'b0;
    rdValid = 1'b0;
    if (!rstN) begin
      streaming = 0; startStream = 0; waitCnt = 0;
    end else begin
      if (startStream) begin
        streaming = 1; startStream = 0; wIdx = 0; gapPh = 0;
      end
      if (streaming) begin
        gapPh = !gapPh;
        if (!gapMode || gapPh) begin
          rdValid = 1'b1;
          rdData  = capSpare ? markerOf(capBlk) : dataOf(capBlk, capPg, wIdx);
          wIdx++;
          if (wIdx == (capSpare ? 1 : PB)) streaming = 0;
        end
      end else if (cmdReq) begin
        if (waitCnt >= gntDelay) begin
          cmdGnt = 1'b1;
          capSpare = cmdSpare; capBlk = int'(cmdBlock); capPg = int'(cmdPage);
          startStream = 1; waitCnt = 0;
        end else begin
          waitCnt++;
        end
      end
    end
  end

  // monitor: samples on the falling edge
  bit rSp[4096];
  int rBlk[4096], rPg[4096], rCol[4096];
  int wAd[4096], wDa[4096];
  int nReq = 0, nWr = 0, doneCnt = 0, doneCyc = 0, lastWrCyc = 0;
  int stabErr = 0, errCnt = 0, reqSeen = 0;
  bit doneBusy = 0, busyBefore = 0, prevBusy = 0, prevReq = 0, prevGnt = 0, pSp = 0;
  int pBlk = 0, pPg = 0, pCol = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (cmdReq && cmdGnt && nReq < 4096) begin
        rSp[nReq] = cmdSpare; rBlk[nReq] = int'(cmdBlock);
        rPg[nReq] = int'(cmdPage); rCol[nReq] = int'(cmdCol);
        nReq++;
      end
      if (cmdReq && prevReq && !prevGnt &&
          (int'(cmdBlock) != pBlk || int'(cmdPage) != pPg ||
           int'(cmdCol) != pCol || cmdSpare != pSp)) stabErr++;
      prevReq = cmdReq; prevGnt = cmdGnt; pSp = cmdSpare;
      pBlk = int'(cmdBlock); pPg = int'(cmdPage); pCol = int'(cmdCol);
      if (memWe && nWr < 4096) begin
        wAd[nWr] = int'(memAddr); wDa[nWr] = int'(memData);
        nWr++; lastWrCyc = cyc;
      end
      if (done) begin
        doneCnt++; doneCyc = cyc; doneBusy = busy; busyBefore = prevBusy;
      end
      if (reqErr) errCnt++;
      if (cmdReq) reqSeen++;
      prevBusy = busy;
    end
  end

  task automatic pulseStart(int offs, int len, int dst);
    @(posedge clk); #1;
    flashOffs = 16'(offs); imageLen = 16'(len); dstAddr = 16'(dst); start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  task automatic runLoad(string nm, int offs, int len, int dst, int gd, bit gap, bit poke);
    int baseR, baseW, baseD, baseS, t, b, lb, lb0, fb, pg, nb, k, w, reqBad, wrBad, lastPages;
    gntDelay = gd; gapMode = gap;
    baseR = nReq; baseW = nWr; baseD = doneCnt; baseS = stabErr;
    pulseStart(offs, len, dst);
    @(negedge clk);
    chk(busy === 1'b1, "R7", {nm, " busy after start"}, int'(busy), 1);
    chk(badCount === 8'd0, "R8", {nm, " badCount cleared"}, int'(badCount), 0);
    if (poke) begin
      repeat (4) @(posedge clk);
      #1; flashOffs = 16'd0; imageLen = 16'd16; start = 1'b1;
      @(posedge clk); #1; start = 1'b0;
    end
    t = 0;
    while (doneCnt == baseD && t < 20000) begin @(negedge clk); t++; end
    @(negedge clk);
    fb = offs / BB; lb = (offs + len - 1) / BB; lb0 = lb; pg = (offs % BB) / PB;
    nb = 0; k = 0; w = 0; reqBad = 0; wrBad = 0;
    b = fb;
    while (b <= lb) begin
      if (baseR + k >= nReq || rSp[baseR+k] != 1'b1 || rBlk[baseR+k] != b ||
          rPg[baseR+k] != 0 || rCol[baseR+k] != MCOL) reqBad++;
      k++;
      if (badMask[b]) begin
        nb++; lb++; b++;
      end else begin
        for (int p = pg; p < PPB; p++) begin
          if (baseR + k >= nReq || rSp[baseR+k] != 1'b0 || rBlk[baseR+k] != b ||
              rPg[baseR+k] != p || rCol[baseR+k] != 0) reqBad++;
          k++;
          for (int wd = 0; wd < PB; wd++) begin
            if (baseW + w >= nWr || wAd[baseW+w] != ((dst + w) & 16'hFFFF) ||
                wDa[baseW+w] != int'(dataOf(b, p, wd))) wrBad++;
            w++;
          end
        end
        pg = 0; b++;
      end
    end
    chk(nReq > baseR && rSp[baseR] == 1'b1 && rBlk[baseR] == fb && rCol[baseR] == MCOL,
        "R2", {nm, " first command block"}, (nReq > baseR) ? rBlk[baseR] : -1, fb);
    chk(nReq - baseR == k, "R3", {nm, " command count"}, nReq - baseR, k);
    chk(reqBad == 0, "R4", {nm, " command sequence mismatches"}, reqBad, 0);
    chk(nWr - baseW == w, "R5", {nm, " write count"}, nWr - baseW, w);
    chk(wrBad == 0, "R5", {nm, " write address/data mismatches"}, wrBad, 0);
    lastPages = 0;
    for (int i = baseR; i < nReq; i++) if (!rSp[i] && rPg[i] == PPB - 1) lastPages++;
    chk(lastPages == lb0 - fb + 1, "R6", {nm, " good blocks loaded"}, lastPages, lb0 - fb + 1);
    chk(int'(badCount) == nb, "R3", {nm, " bad block count"}, int'(badCount), nb);
    chk(doneCnt - baseD == 1, "R7", {nm, " done pulses"}, doneCnt - baseD, 1);
    chk(doneCyc == lastWrCyc + 1, "R7", {nm, " done after last write"}, doneCyc, lastWrCyc + 1);
    chk(!doneBusy && busyBefore, "R7", {nm, " busy around done"}, int'(doneBusy), 0);
    chk(stabErr == baseS, "R9", {nm, " request held while waiting"}, stabErr - baseS, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!busy && !done && !reqErr, "R7", "reset: busy/done/reqErr low", int'(busy), 0);
    chk(!cmdReq && !memWe, "R7", "reset: no command or write", int'(cmdReq), 0);
    chk(badCount == 8'd0, "R8", "reset: badCount", int'(badCount), 0);
  endtask

  task automatic testRefuse(string nm, int offs, int len);
    int r0 = reqSeen;
    int e0 = errCnt;
    pulseStart(offs, len, 0);
    @(negedge clk);
    chk(reqErr === 1'b1, "R1", {nm, " reqErr after start"}, int'(reqErr), 1);
    chk(busy === 1'b0, "R1", {nm, " busy stays low"}, int'(busy), 0);
    repeat (5) @(negedge clk);
    chk(errCnt - e0 == 1, "R1", {nm, " reqErr single cycle"}, errCnt - e0, 1);
    chk(reqSeen == r0, "R1", {nm, " no command issued"}, reqSeen - r0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    testReset();
    #1 rstN = 1'b1;
    repeat (2) @(posedge clk);
    testRefuse("unaligned offset", 72, 32);
    testRefuse("zero length", 64, 0);
    badMask = '0;
    runLoad("mid-block start", 96, 80, 16'h0200, 0, 0, 0);
    badMask = '0; badMask[1] = 1'b1; badMask[2] = 1'b1;
    runLoad("two bad blocks + start while busy (R10)", 0, 128, 16'h1000, 2, 1, 1);
    repeat (5) @(negedge clk);
    chk(badCount == 8'd2, "R8", "badCount held after done", int'(badCount), 2);
    badMask = '0; badMask[2] = 1'b1;
    runLoad("first block bad keeps start page", 176, 16, 16'h0040, 1, 0, 0);
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

endmodule